// File: doc/BRIEF.md
# Size-Configurable Parallel SAD Tree

This block computes sums of absolute differences (SAD) between a current block and a candidate reference block of 8-bit pixels for a motion-estimation datapath. In every accepted cycle it takes a 32×32 beat of 1024 current and 1024 reference pixels. One fixed adder tree serves all ten prediction-unit shapes from 64×64 down to 8×8. Shapes wider or taller than 32 are fed as two or four 32×32 beats, and their partial sums are added into an accumulator. Shapes smaller than 32×32 read intermediate nodes of the same tree, so one beat returns up to sixteen independent SADs.

The caller presents a beat with `in_valid` and a shape code. After a fixed pipeline delay the block raises `res_valid` for one cycle, with the number of results and the packed result vector. Slot k occupies bits `res_sad[k*20 +: 20]`. A new beat can be accepted in every cycle.

Top module: `sad_tree_multi`

## Requirements
- R1: Each current/reference pixel pair adds |cur − ref| to the SAD. Pixel (x,y) of a 32×32 beat, with x the column and y the row, sits in lane ((y/16)*8 + (x/16)*4 + ((y/8)%2)*2 + (x/8)%2)*64 + (y%8)*8 + (x%8) of each pixel vector, at bits lane*8 +: 8.
- R2: Shape codes (width×height) are: 0 = 8×8, 1 = 16×8, 2 = 8×16, 3 = 16×16, 4 = 32×16, 5 = 16×32, 6 = 32×32, 7 = 64×32, 8 = 32×64, 9 = 64×64. Code 6 gives one result from one beat, in slot 0, with count 1.
- R3: Codes 7 and 8 need two accepted beats. The single result, with count 1, is the sum of the SADs of both beats and appears only after the second beat.
- R4: Code 9 needs four accepted beats. The single result is the sum of the SADs of all four beats.
- R5: Code 0 returns 16 results. Slot k holds the 8×8 block in column k%4 and row k/4 of the beat.
- R6: Code 1 returns 8 results, with slot k in column k%2 and row k/2. Code 2 returns 8 results, with slot k in column k%4 and row k/4.
- R7: Code 3 returns 4 results in a 2×2 raster. Code 4 returns 2 results, slot 0 the top half. Code 5 returns 2 results, slot 0 the left half.
- R8: After reset, `res_valid`, `res_count` and every slot are 0. The result of a beat accepted at rising edge k is shown after edge k+2, and one beat can be accepted in every cycle.
- R9: A beat carrying a code from 10 to 15 is ignored. It produces no result and does not count as a beat of a multi-beat group.
- R10: While `res_valid` is high, every slot with index at or above `res_count` is 0.
- R11: `res_valid` is high for exactly one cycle per result. Between results, `res_count` and `res_sad` hold the last result.
- R12: The beats of a multi-beat group are the next accepted beats. Idle cycles between them do not break the group.
- R13: The 20-bit result is exact up to the largest 64×64 SAD, 1,044,480.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Beat present this cycle |
| pu_size | input | 4 | Shape code of the beat |
| cur_pix | input | 8192 | 1024 current-block pixels, lane layout per R1 |
| ref_pix | input | 8192 | 1024 reference-block pixels, same layout |
| res_valid | output | 1 | Result vector valid this cycle |
| res_count | output | 5 | Number of results (1 to 16) |
| res_sad | output | 320 | Sixteen 20-bit SAD slots |

## Verification
The hardest state to reach is a multi-beat group that is interrupted. The block must keep its beat position and running sum across idle cycles and across beats with illegal codes, and then close the group on the correct later beat. The stimulus puts idle cycles and an illegal-code beat inside a 64×64 group. It also runs a 64×64 group with every pixel pair at the maximum difference, to reach the top of the result range. Separately, long back-to-back streams of mixed small shapes show that results follow one another with no bubble and in the correct slot order.

// File: rtl/sadt_pkg.sv
package sadt_pkg;
  localparam int SIDE   = 32;
  localparam int SUB    = 8;
  localparam int NPIX   = SIDE * SIDE;
  localparam int SUBPIX = SUB * SUB;
  localparam int NSUB   = (SIDE / SUB) * (SIDE / SUB);
  localparam int CNT_W  = $clog2(NSUB + 1);

  localparam logic [3:0] SZ_8X8   = 4'd0;
  localparam logic [3:0] SZ_16X8  = 4'd1;
  localparam logic [3:0] SZ_8X16  = 4'd2;
  localparam logic [3:0] SZ_16X16 = 4'd3;
  localparam logic [3:0] SZ_32X16 = 4'd4;
  localparam logic [3:0] SZ_16X32 = 4'd5;
  localparam logic [3:0] SZ_32X32 = 4'd6;
  localparam logic [3:0] SZ_64X32 = 4'd7;
  localparam logic [3:0] SZ_32X64 = 4'd8;
  localparam logic [3:0] SZ_64X64 = 4'd9;

  function automatic logic size_legal(input logic [3:0] code);
    return code <= SZ_64X64;
  endfunction

  function automatic logic [2:0] size_beats(input logic [3:0] code);
    logic [2:0] n;
    case (code)
      SZ_64X32, SZ_32X64: n = 3'd2;
      SZ_64X64:           n = 3'd4;
      default:            n = 3'd1;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/sad_absdiff.sv
module sad_absdiff #(
  parameter int PIX_W = 8,
  parameter int NPIX  = 1024
) (
  input  logic                  clk,
  input  logic                  en,
  input  logic [NPIX*PIX_W-1:0] cur_pix,
  input  logic [NPIX*PIX_W-1:0] ref_pix,
  output logic [NPIX*PIX_W-1:0] ad_q
);
  logic [NPIX*PIX_W-1:0] ad_d;

  for (genvar i = 0; i < NPIX; i++) begin : g_ad
    logic [PIX_W-1:0] c, r;
    assign c = cur_pix[i*PIX_W +: PIX_W];
    assign r = ref_pix[i*PIX_W +: PIX_W];
    assign ad_d[i*PIX_W +: PIX_W] = (c > r) ? (c - r) : (r - c);
  end

  // datapath register, loaded only on accepted beats
  always_ff @(posedge clk) begin
    if (en) ad_q <= ad_d;
  end
endmodule

// File: rtl/sad_subtree.sv
module sad_subtree #(
  parameter int IN_W  = 8,
  parameter int OUT_W = 20,
  parameter int N     = 64
) (
  input  logic [N*IN_W-1:0] leaf,
  output logic [OUT_W-1:0]  sum
);
  localparam int LVLS = $clog2(N);

  for (genvar l = 0; l <= LVLS; l++) begin : g_lv
    localparam int CNT = N >> l;
    logic [OUT_W-1:0] s [CNT];
    if (l == 0) begin : g_leaf
      for (genvar i = 0; i < CNT; i++) begin : g_i
        assign s[i] = {{(OUT_W-IN_W){1'b0}}, leaf[i*IN_W +: IN_W]};
      end
    end else begin : g_add
      for (genvar i = 0; i < CNT; i++) begin : g_i
        assign s[i] = g_lv[l-1].s[2*i] + g_lv[l-1].s[2*i+1];
      end
    end
  end

  assign sum = g_lv[LVLS].s[0];
endmodule

// File: rtl/sad_combine.sv
module sad_combine
  import sadt_pkg::*;
#(
  parameter int RES_W = 20
) (
  input  logic [NSUB*RES_W-1:0] blk_sum,
  input  logic [3:0]            size,
  output logic [NSUB*RES_W-1:0] slot_sum,
  output logic [CNT_W-1:0]      slot_cnt,
  output logic [RES_W-1:0]      full_sum
);
  // blk_sum lanes are in interleaved order {y1,x1,y0,x0} of the 8x8 grid
  logic [RES_W-1:0] s8 [16];
  logic [RES_W-1:0] s16x8 [8];
  logic [RES_W-1:0] s8x16 [8];
  logic [RES_W-1:0] s16 [4];
  logic [RES_W-1:0] s32x16 [2];
  logic [RES_W-1:0] s16x32 [2];
  logic [RES_W-1:0] r8x8 [16];
  logic [RES_W-1:0] r16x8 [8];
  logic [RES_W-1:0] slot [16];

  for (genvar i = 0; i < 16; i++) begin : g_in
    assign s8[i] = blk_sum[i*RES_W +: RES_W];
    // raster slot i -> column {x1,x0} = i%4, row {y1,y0} = i/4
    assign r8x8[i] = s8[(i/8)*8 + ((i/2)%2)*4 + ((i/4)%2)*2 + (i%2)];
    assign slot_sum[i*RES_W +: RES_W] = slot[i];
  end

  for (genvar m = 0; m < 8; m++) begin : g_pair
    assign s16x8[m] = s8[2*m] + s8[2*m+1];                  // pair across x0
    assign s8x16[m] = s8[(m/2)*4 + (m%2)] + s8[(m/2)*4 + (m%2) + 2]; // across y0
    // raster slot m -> column x1 = m%2, row {y1,y0} = m/2
    assign r16x8[m] = s16x8[(m/4)*4 + (m%2)*2 + ((m/2)%2)];
  end

  for (genvar q = 0; q < 4; q++) begin : g_quad
    assign s16[q] = s16x8[2*q] + s16x8[2*q+1];
  end

  for (genvar t = 0; t < 2; t++) begin : g_half
    assign s32x16[t] = s16[2*t] + s16[2*t+1];
    assign s16x32[t] = s16[t] + s16[t+2];
  end

  assign full_sum = s32x16[0] + s32x16[1];

  always_comb begin
    for (int k = 0; k < 16; k++) slot[k] = '0;
    slot_cnt = CNT_W'(1);
    case (size)
      SZ_8X8: begin
        for (int k = 0; k < 16; k++) slot[k] = r8x8[k];
        slot_cnt = CNT_W'(16);
      end
      SZ_16X8: begin
        for (int k = 0; k < 8; k++) slot[k] = r16x8[k];
        slot_cnt = CNT_W'(8);
      end
      SZ_8X16: begin
        for (int k = 0; k < 8; k++) slot[k] = s8x16[k];
        slot_cnt = CNT_W'(8);
      end
      SZ_16X16: begin
        for (int k = 0; k < 4; k++) slot[k] = s16[k];
        slot_cnt = CNT_W'(4);
      end
      SZ_32X16: begin
        slot[0] = s32x16[0];
        slot[1] = s32x16[1];
        slot_cnt = CNT_W'(2);
      end
      SZ_16X32: begin
        slot[0] = s16x32[0];
        slot[1] = s16x32[1];
        slot_cnt = CNT_W'(2);
      end
      default: slot[0] = full_sum;
    endcase
  end
endmodule

// File: rtl/sad_tree_multi.sv
module sad_tree_multi
  import sadt_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int RES_W = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [3:0]            pu_size,
  input  logic [NPIX*PIX_W-1:0] cur_pix,
  input  logic [NPIX*PIX_W-1:0] ref_pix,
  output logic                  res_valid,
  output logic [CNT_W-1:0]      res_count,
  output logic [NSUB*RES_W-1:0] res_sad
);
  // register stages from accepted beat to outputs
  localparam int PIPE_LAT = 3;
  localparam int BEAT_W   = 3;

  // ---------------- beat tracking ----------------
  logic [BEAT_W-1:0] beat_q, beat_d, nbeats;
  logic              accept, in_first, in_last;

  always_comb begin
    nbeats   = size_beats(pu_size);
    accept   = in_valid & size_legal(pu_size);
    in_first = (beat_q == '0);
    in_last  = (beat_q == nbeats - 3'd1);
    beat_d   = in_last ? '0 : beat_q + 3'd1;
  end

  // ---------------- stage A: absolute differences ----------------
  logic                  a_vld, a_first, a_last;
  logic [3:0]            a_size;
  logic [NPIX*PIX_W-1:0] ad_q;

  sad_absdiff #(.PIX_W(PIX_W), .NPIX(NPIX)) u_absdiff (
    .clk     (clk),
    .en      (accept),
    .cur_pix (cur_pix),
    .ref_pix (ref_pix),
    .ad_q    (ad_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q  <= '0;
      a_vld   <= 1'b0;
      a_first <= 1'b0;
      a_last  <= 1'b0;
      a_size  <= '0;
    end else begin
      a_vld <= accept;
      if (accept) begin
        beat_q  <= beat_d;
        a_size  <= pu_size;
        a_first <= in_first;
        a_last  <= in_last;
      end
    end
  end

  // ---------------- stage B: 8x8 subtree sums ----------------
  logic [NSUB*RES_W-1:0] blk_d, blk_q;
  logic                  b_vld, b_first, b_last;
  logic [3:0]            b_size;

  for (genvar s = 0; s < NSUB; s++) begin : g_sub
    sad_subtree #(.IN_W(PIX_W), .OUT_W(RES_W), .N(SUBPIX)) u_subtree (
      .leaf (ad_q[s*SUBPIX*PIX_W +: SUBPIX*PIX_W]),
      .sum  (blk_d[s*RES_W +: RES_W])
    );
  end

  always_ff @(posedge clk) begin
    if (a_vld) blk_q <= blk_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_vld   <= 1'b0;
      b_first <= 1'b0;
      b_last  <= 1'b0;
      b_size  <= '0;
    end else begin
      b_vld <= a_vld;
      if (a_vld) begin
        b_size  <= a_size;
        b_first <= a_first;
        b_last  <= a_last;
      end
    end
  end

  // ---------------- stage C: combine, accumulate, output ----------------
  logic [NSUB*RES_W-1:0] slot_d, out_d;
  logic [CNT_W-1:0]      cnt_d;
  logic [RES_W-1:0]      full_sum, acc_q, acc_d;
  logic                  out_en;

  sad_combine #(.RES_W(RES_W)) u_combine (
    .blk_sum  (blk_q),
    .size     (b_size),
    .slot_sum (slot_d),
    .slot_cnt (cnt_d),
    .full_sum (full_sum)
  );

  always_comb begin
    acc_d  = b_first ? full_sum : (acc_q + full_sum);
    out_en = b_vld & b_last;
    out_d  = slot_d;
    if (b_size >= SZ_32X32) out_d[RES_W-1:0] = acc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      res_valid <= 1'b0;
      res_count <= '0;
      res_sad   <= '0;
    end else begin
      res_valid <= out_en;
      if (b_vld) acc_q <= acc_d;
      if (out_en) begin
        res_count <= cnt_d;
        res_sad   <= out_d;
      end
    end
  end
endmodule

// File: rtl/sad_tree_multi_chk.sv
module sad_tree_multi_chk
  import sadt_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int RES_W = 20
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic [3:0]            pu_size,
  input logic                  res_valid,
  input logic [CNT_W-1:0]      res_count,
  input logic [NSUB*RES_W-1:0] res_sad
);
  localparam int MAX_SAD = 4 * NPIX * ((1 << PIX_W) - 1);

  function automatic logic [CNT_W-1:0] want_cnt(input logic [3:0] c);
    case (c)
      4'd0:       return CNT_W'(16);
      4'd1, 4'd2: return CNT_W'(8);
      4'd3:       return CNT_W'(4);
      4'd4, 4'd5: return CNT_W'(2);
      default:    return CNT_W'(1);
    endcase
  endfunction

  logic hi_nz;
  always_comb begin
    hi_nz = 1'b0;
    for (int i = 0; i < NSUB; i++)
      if (i >= int'(res_count) && res_sad[i*RES_W +: RES_W] != '0) hi_nz = 1'b1;
  end

  assert_result_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(in_valid, 3));

  assert_illegal_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($past(pu_size, 3) <= 4'd9));

  assert_count_by_size_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_count == want_cnt($past(pu_size, 3))));

  assert_unused_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !hi_nz);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(res_sad) && $stable(res_count)));

  assert_no_overflow_R13: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (int'(res_sad[RES_W-1:0]) <= MAX_SAD));
endmodule

bind sad_tree_multi sad_tree_multi_chk #(.PIX_W(PIX_W), .RES_W(RES_W)) i_chk (.*);

// File: tb/test_sad_tree_multi.sv
module test_sad_tree_multi;
  import sadt_pkg::*;
  localparam int RW = 20;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                in_valid;
  logic [3:0]          pu_size;
  logic [NPIX*8-1:0]   cur_pix, ref_pix;
  logic                res_valid;
  logic [CNT_W-1:0]    res_count;
  logic [NSUB*RW-1:0]  res_sad;

  always #10 clk = ~clk;

  sad_tree_multi i_sad_tree_multi (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pu_size(pu_size),
    .cur_pix(cur_pix), .ref_pix(ref_pix),
    .res_valid(res_valid), .res_count(res_count), .res_sad(res_sad)
  );

  typedef struct {
    bit v;
    int cnt;
    int s [16];
    int req;
  } exp_t;

  int   n_tests = 0;
  int   n_fail  = 0;
  int   ic [32][32];
  int   ir [32][32];
  exp_t q [$];
  exp_t st;
  int   m_beat = 0;
  int   m_acc  = 0;
  int   tag_over = 0;

  // R1 lane layout
  function automatic int lane(int x, int y);
    int blk;
    blk = (y/16)*8 + (x/16)*4 + ((y/8)%2)*2 + ((x/8)%2);
    return blk*64 + (y%8)*8 + (x%8);
  endfunction

  function automatic int rsad(int x0, int y0, int w, int h);
    int acc = 0;
    for (int y = y0; y < y0 + h; y++)
      for (int x = x0; x < x0 + w; x++)
        acc += (ic[y][x] > ir[y][x]) ? ic[y][x] - ir[y][x] : ir[y][x] - ic[y][x];
    return acc;
  endfunction

  function automatic int shape_w(int sz);
    case (sz) 0: return 8; 1: return 16; 2: return 8; 3: return 16;
      4: return 32; 5: return 16; default: return 32; endcase
  endfunction

  function automatic int shape_h(int sz);
    case (sz) 0: return 8; 1: return 8; 2: return 16; 3: return 16;
      4: return 16; 5: return 32; default: return 32; endcase
  endfunction

  function automatic int req_of(int sz);
    if (sz == 0) return 5;
    if (sz <= 2) return 6;
    if (sz <= 5) return 7;
    return 2;
  endfunction

  task automatic fill_rand();
    for (int y = 0; y < 32; y++)
      for (int x = 0; x < 32; x++) begin
        ic[y][x] = $urandom_range(0, 255);
        ir[y][x] = $urandom_range(0, 255);
      end
  endtask

  task automatic fill_const(int c, int r);
    for (int y = 0; y < 32; y++)
      for (int x = 0; x < 32; x++) begin
        ic[y][x] = c;
        ir[y][x] = r;
      end
  endtask

  task automatic pack();
    for (int y = 0; y < 32; y++)
      for (int x = 0; x < 32; x++) begin
        cur_pix[lane(x, y)*8 +: 8] = 8'(ic[y][x]);
        ref_pix[lane(x, y)*8 +: 8] = 8'(ir[y][x]);
      end
  endtask

  task automatic check(string what, int req, int got, int want);
    n_tests++;
    if (got != want) begin
      n_fail++;
      $display("FAIL R%0d %s: got %0d expected %0d", req, what, got, want);
    end
  endtask

  // R8 valid timing; R10 unused slots; R11 hold between results
  task automatic compare(exp_t e);
    int r;
    check("res_valid", 8, int'(res_valid), int'(e.v));
    r = e.v ? e.req : 11;
    check("res_count", r, int'(res_count), e.cnt);
    for (int k = 0; k < 16; k++)
      check($sformatf("slot %0d", k), (e.v && k >= e.cnt) ? 10 : r,
            int'(res_sad[k*RW +: RW]), e.s[k]);
  endtask

  task automatic step(int sz, bit vld);
    exp_t e;
    e = st;
    e.v = 1'b0;
    in_valid = vld;
    pu_size  = 4'(sz);
    pack();
    if (vld && sz <= 6) begin
      int w, h, nx, ny;
      w = shape_w(sz); h = shape_h(sz);
      nx = 32 / w; ny = 32 / h;
      e.v = 1'b1; e.cnt = nx * ny; e.req = req_of(sz);
      for (int k = 0; k < 16; k++)
        e.s[k] = (k < e.cnt) ? rsad((k % nx) * w, (k / nx) * h, w, h) : 0;
    end else if (vld && sz <= 9) begin
      int nb, s;
      nb = (sz == 9) ? 4 : 2;
      s  = rsad(0, 0, 32, 32);
      m_acc  = (m_beat == 0) ? s : m_acc + s;
      m_beat = m_beat + 1;
      if (m_beat == nb) begin
        m_beat = 0;
        e.v = 1'b1; e.cnt = 1;
        e.req = (tag_over != 0) ? tag_over : ((sz == 9) ? 4 : 3);
        for (int k = 0; k < 16; k++) e.s[k] = 0;
        e.s[0] = m_acc;
      end
    end
    if (e.v) st = e;
    q.push_back(e);
    @(posedge clk);
    @(negedge clk);
    compare(q.pop_front());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; pu_size = '0;
    cur_pix = '0; ref_pix = '0;
    st.v = 1'b0; st.cnt = 0; st.req = 8;
    for (int k = 0; k < 16; k++) st.s[k] = 0;
    repeat (3) @(negedge clk);
    // R8 reset state
    check("reset res_valid", 8, int'(res_valid), 0);
    check("reset res_count", 8, int'(res_count), 0);
    for (int k = 0; k < 16; k++) check("reset slot", 8, int'(res_sad[k*RW +: RW]), 0);
    rst_n = 1'b1;
    q.push_back(st);
    q.push_back(st);

    // R2 R5 R6 R7: every single-beat shape, R1 layout through raster slots
    for (int rep = 0; rep < 3; rep++)
      for (int sz = 0; sz <= 6; sz++) begin
        fill_rand();
        step(sz, 1'b1);
      end
    step(0, 1'b0);

    // R3: two-beat shapes back to back
    for (int sz = 7; sz <= 8; sz++)
      for (int b = 0; b < 2; b++) begin
        fill_rand();
        step(sz, 1'b1);
      end
    // R4: four beats
    for (int b = 0; b < 4; b++) begin
      fill_rand();
      step(9, 1'b1);
    end
    step(0, 1'b0);

    // R12 idle gaps inside a group, R9 illegal code inside the group
    fill_rand(); step(9, 1'b1);
    step(9, 1'b0);
    fill_rand(); step(9, 1'b1);
    fill_rand(); step(12, 1'b1);
    fill_rand(); step(9, 1'b1);
    step(9, 1'b0);
    step(0, 1'b0);
    fill_rand(); step(9, 1'b1);
    step(0, 1'b0);

    // R13: largest 64x64 SAD
    tag_over = 13;
    fill_const(255, 0);
    for (int b = 0; b < 4; b++) step(9, 1'b1);
    tag_over = 0;
    fill_const(0, 255);
    step(0, 1'b1);

    // R8 throughput: back-to-back mixed shapes
    for (int i = 0; i < 24; i++) begin
      fill_rand();
      step($urandom_range(0, 6), 1'b1);
    end

    // R9 R11: illegal codes alone, outputs hold
    for (int c = 10; c <= 15; c++) begin
      fill_rand();
      step(c, 1'b1);
    end
    // R3 after illegal beats: group starts cleanly
    fill_rand(); step(8, 1'b1);
    fill_rand(); step(15, 1'b1);
    fill_rand(); step(8, 1'b1);

    for (int i = 0; i < 4; i++) step(0, 1'b0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule